// File: doc/BRIEF.md
# Word-Boundary Phase Tracker

This block sits in the fast clock domain of a double-data-rate serializer. The fast clock runs at 3.5 times a slow word clock, so seven serial bits fill each slow period. Both clocks come from one reference and keep a fixed phase relation: every seven fast cycles, which is two slow periods, a fast rising edge lines up with a slow rising edge. The slow rising edge halfway between those lines up with a fast falling edge. The slow domain supplies a single flop that inverts once per word. The tracker never samples the slow clock itself. It captures that toggle on both edges of the fast clock and, from each pair of captures, finds the fast cycle that begins at the shared rising edge.

Once it has found that cycle, the tracker runs a seven-state cell counter across the two-word span. The counter reports the current bit cell and which of the two words is active. While locked, it raises a load strobe in a fixed cell so that the serializer can capture the next parallel word with setup margin. The alignment is checked again on every span, and any disagreement drops lock, so a phase slip or a spurious toggle is caught rather than trusted forever.

Top module: `word_phase_tracker`

## Requirements
- R1: While `rst_i` is high at a rising edge, the block's outputs after that edge are: `locked_o`=0, `cell_o`=0, `load_o`=0 and `word_o`=0.
- R2: A detection occurs at a rising edge when two captures of `tog_i` taken in the cycle that just ended differ: the capture at that cycle's rising edge and the capture at its falling edge. This happens when the toggle changed just after the cycle's opening rising edge. If the block holds no phase hypothesis, a detection sets `cell_o` to 1 for the following cycle. Without a detection, `cell_o` stays 0.
- R3: While a hypothesis is held and every check agrees, `cell_o` advances by one per fast cycle through 0..6 and wraps from 6 to 0.
- R4: A check agrees when a detection occurs exactly at the edge that ends a cycle in which `cell_o` was 0. `locked_o` rises in the cycle after the second agreeing detection: the one that started the hypothesis, then one confirmation.
- R5: A check disagrees when there is a detection while `cell_o` is not 0, or no detection while `cell_o` is 0. On a disagreement, `locked_o` drops in the next cycle. If the disagreement was a detection, the hypothesis restarts with `cell_o`=1. Otherwise the hypothesis is discarded and `cell_o` returns to 0.
- R6: `load_o` is 1 exactly in cycles where `locked_o`=1 and `cell_o`=5. It is never 1 while unlocked.
- R7: `word_o` is 1 when `cell_o` is 4, 5 or 6 (the second word of the span) and 0 when `cell_o` is 0 to 3.
- R8: Toggle activity while reset is held causes no detection: after release, `cell_o` remains 0 until the first detection made with reset low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast serializer clock (3.5x the word clock) |
| rst_i | input | 1 | Synchronous active-high reset |
| tog_i | input | 1 | Slow-domain flop that inverts once per word |
| locked_o | output | 1 | Phase confirmed and still agreeing |
| cell_o | output | $clog2(CELLS) | Current bit cell within the two-word span |
| word_o | output | 1 | 1 while the second word of the span is active |
| load_o | output | 1 | Load strobe in the fixed cell, only while locked |

## Verification
The hardest situations to reach from the ports are phase disturbances. They include a toggle that arrives one half-cycle early or late, so that the word boundary moves onto a falling edge, and a toggle that flips and flips back within a cycle. In both cases the detections stop matching the running counter. The bench drives the toggle from a half-cycle scheduler and, at random points under a fixed seed, pulls the next toggle in or pushes it out by one edge. It also injects immediate glitches and reset pulses while the toggle keeps running. Each cycle it compares every output with a model built from the requirements, so the bench covers lock loss, restart from a detection, discarding the hypothesis, and relocking.

// File: rtl/wpt_pkg.sv
`timescale 1ns/1ps
package wpt_pkg;
  // Command from the lock controller to the cell counter
  typedef enum logic [1:0] {
    CMD_WAIT  = 2'd0,   // hold the counter at cell 0
    CMD_START = 2'd1,   // a boundary was just seen: next cell is 1
    CMD_STEP  = 2'd2    // advance by one cell, wrapping
  } cell_cmd_e;

  typedef enum logic {
    TRK_HUNT  = 1'b0,   // no phase hypothesis
    TRK_TRACK = 1'b1    // hypothesis held, checked every span
  } trk_state_e;
endpackage

// File: rtl/wpt_edge_sampler.sv
`timescale 1ns/1ps
module wpt_edge_sampler (
  input  logic clk_i,
  input  logic rst_i,
  input  logic tog_i,
  output logic hit_o
);
  // Both captures are taken with no extra stages: the fixed phase relation
  // keeps each capture away from the toggle's transition.
  logic rise_q;
  logic fall_q;

  always_ff @(posedge clk_i) begin
    rise_q <= tog_i;
  end

  always_ff @(negedge clk_i) begin
    fall_q <= tog_i;
  end

  // Values differ only when the toggle moved just after the rising edge
  // that opened the cycle now ending: that edge is the shared one.
  assign hit_o = !rst_i && (rise_q != fall_q);
endmodule

// File: rtl/wpt_cell_counter.sv
`timescale 1ns/1ps
module wpt_cell_counter
  import wpt_pkg::*;
#(
  parameter int unsigned CELLS = 7,
  parameter int unsigned CNT_W = $clog2(CELLS)
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  cell_cmd_e        cmd_i,
  output logic [CNT_W-1:0] cell_q_o,
  output logic [CNT_W-1:0] cell_nxt_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CELLS - 1);

  logic [CNT_W-1:0] cell_q;

  always_comb begin
    unique case (cmd_i)
      CMD_START: cell_nxt_o = CNT_W'(1);
      CMD_STEP:  cell_nxt_o = (cell_q == LAST) ? '0 : cell_q + 1'b1;
      default:   cell_nxt_o = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) cell_q <= '0;
    else       cell_q <= cell_nxt_o;
  end

  assign cell_q_o = cell_q;

  AST_CELL_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
    cell_q < CNT_W'(CELLS)); // R3
endmodule

// File: rtl/wpt_lock_ctrl.sv
`timescale 1ns/1ps
module wpt_lock_ctrl
  import wpt_pkg::*;
#(
  parameter int unsigned CELLS     = 7,
  parameter int unsigned CNT_W     = $clog2(CELLS),
  parameter int unsigned LOCK_HITS = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             hit_i,
  input  logic [CNT_W-1:0] cell_i,
  output cell_cmd_e        cmd_o,
  output logic             locked_o,
  output logic             locked_nxt_o
);
  localparam int unsigned GW = $clog2(LOCK_HITS + 1);

  trk_state_e    state_q, state_nxt;
  logic [GW-1:0] good_q, good_nxt;
  logic          locked_q;
  logic          agree;

  // A boundary is expected exactly at the edge closing cell 0
  assign agree = (hit_i == (cell_i == '0));

  always_comb begin
    state_nxt = state_q;
    good_nxt  = good_q;
    cmd_o     = CMD_WAIT;
    unique case (state_q)
      TRK_HUNT: begin
        if (hit_i) begin
          cmd_o     = CMD_START;
          state_nxt = TRK_TRACK;
          good_nxt  = GW'(1);
        end
      end
      default: begin
        if (agree) begin
          cmd_o = CMD_STEP;
          if (hit_i && (good_q < GW'(LOCK_HITS))) good_nxt = good_q + 1'b1;
        end else if (hit_i) begin
          cmd_o    = CMD_START;
          good_nxt = GW'(1);
        end else begin
          state_nxt = TRK_HUNT;
          good_nxt  = '0;
        end
      end
    endcase
    locked_nxt_o = (state_nxt == TRK_TRACK) && (good_nxt >= GW'(LOCK_HITS));
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q  <= TRK_HUNT;
      good_q   <= '0;
      locked_q <= 1'b0;
    end else begin
      state_q  <= state_nxt;
      good_q   <= good_nxt;
      locked_q <= locked_nxt_o;
    end
  end

  assign locked_o = locked_q;

  AST_LOCK_IN_TRACK: assert property (@(posedge clk_i) disable iff (rst_i)
    locked_q |-> (state_q == TRK_TRACK)); // R4
  AST_DROP_ON_MISS: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_q == TRK_TRACK && !agree) |=> !locked_q); // R5
  AST_HUNT_START: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_q == TRK_HUNT && hit_i) |=> (cell_i == CNT_W'(1))); // R2
endmodule

// File: rtl/word_phase_tracker.sv
`timescale 1ns/1ps
module word_phase_tracker
  import wpt_pkg::*;
#(
  parameter int unsigned CELLS     = 7,
  parameter int unsigned LOAD_SLOT = 5,
  parameter int unsigned LOCK_HITS = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_i,
  input  logic                     tog_i,
  output logic                     locked_o,
  output logic [$clog2(CELLS)-1:0] cell_o,
  output logic                     word_o,
  output logic                     load_o
);
  localparam int unsigned CNT_W       = $clog2(CELLS);
  localparam int unsigned SECOND_WORD = (CELLS + 1) / 2;

  logic             hit;
  cell_cmd_e        cmd;
  logic [CNT_W-1:0] cell_q, cell_nxt;
  logic             locked_nxt;
  logic             load_q, word_q;

  wpt_edge_sampler u_sampler (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .tog_i (tog_i),
    .hit_o (hit)
  );

  wpt_cell_counter #(.CELLS(CELLS), .CNT_W(CNT_W)) u_counter (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .cmd_i      (cmd),
    .cell_q_o   (cell_q),
    .cell_nxt_o (cell_nxt)
  );

  wpt_lock_ctrl #(.CELLS(CELLS), .CNT_W(CNT_W), .LOCK_HITS(LOCK_HITS)) u_ctrl (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .hit_i        (hit),
    .cell_i       (cell_q),
    .cmd_o        (cmd),
    .locked_o     (locked_o),
    .locked_nxt_o (locked_nxt)
  );

  // Strobe and word flag are registered from the next-state values so they
  // line up with the cell they describe.
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      load_q <= 1'b0;
      word_q <= 1'b0;
    end else begin
      load_q <= locked_nxt && (cell_nxt == CNT_W'(LOAD_SLOT));
      word_q <= (cell_nxt >= CNT_W'(SECOND_WORD));
    end
  end

  assign cell_o = cell_q;
  assign load_o = load_q;
  assign word_o = word_q;

  AST_RESET_CLEAR: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(rst_i) |-> (!locked_o && cell_o == '0 && !load_o && !word_o)); // R1
  AST_LOAD_GATED: assert property (@(posedge clk_i) disable iff (rst_i)
    load_o |-> (locked_o && cell_o == CNT_W'(LOAD_SLOT))); // R6
  AST_WORD_FLAG: assert property (@(posedge clk_i) disable iff (rst_i)
    word_o == (cell_o >= CNT_W'(SECOND_WORD))); // R7
  AST_LOCK_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
    locked_o |=> (!locked_o ||
      cell_o == (($past(cell_o) == CNT_W'(CELLS - 1)) ? '0 : $past(cell_o) + 1'b1))); // R3
endmodule

// File: tb/word_phase_tracker_tb_top.sv
`timescale 1ns/1ps
module word_phase_tracker_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tog = 1'b0;
  logic       locked_o, word_o, load_o;
  logic [2:0] cell_o;

  always #2.5 clk = ~clk;   // 200 MHz

  word_phase_tracker dut_i (
    .clk_i    (clk),
    .rst_i    (rst),
    .tog_i    (tog),
    .locked_o (locked_o),
    .cell_o   (cell_o),
    .word_o   (word_o),
    .load_o   (load_o)
  );

  int vectors = 0;
  int fails   = 0;
  int lock_seen = 0;
  int load_seen = 0;

  // Reference state derived from the requirements
  int m_ph = 0;
  int m_good = 0;
  bit m_track = 0, m_locked = 0, m_load = 0, m_word = 0;
  bit p_last = 0, n_last = 0;
  bit r_at_edge = 1;
  int hc = 1;          // edges until the next toggle flip
  int gap = 7;         // 7 half-cycles = one word period

  task automatic chk(string tag, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_edge(bit r, bit h);
    if (r) begin
      m_track = 0; m_good = 0; m_ph = 0;
    end else if (!m_track) begin
      if (h) begin m_track = 1; m_ph = 1; m_good = 1; end
    end else if (h == (m_ph == 0)) begin
      m_ph = (m_ph == 6) ? 0 : m_ph + 1;
      if (h && m_good < 2) m_good++;
    end else if (h) begin
      m_ph = 1; m_good = 1;
    end else begin
      m_track = 0; m_good = 0; m_ph = 0;
    end
    m_locked = !r && m_track && (m_good >= 2);
    m_load   = m_locked && (m_ph == 5);
    m_word   = (m_ph >= 4);
  endtask

  task automatic half_edge();
    hc--;
    if (hc <= 0) begin
      #1 tog = ~tog;
      hc = gap;
    end else begin
      #1;
    end
  endtask

  task automatic cycle();
    bit h;
    @(posedge clk);
    r_at_edge = rst;
    h = !rst && (p_last != n_last);       // R2 detection rule
    model_edge(rst, h);
    p_last = tog;
    half_edge();
    #1;
    if (r_at_edge) begin
      chk("R1/R8", "locked", locked_o, 0);
      chk("R1/R8", "cell",   cell_o,   0);
      chk("R1",    "load",   load_o,   0);
      chk("R1",    "word",   word_o,   0);
    end else begin
      chk("R2/R3", "cell",   cell_o,   m_ph);
      chk("R4/R5", "locked", locked_o, m_locked);
      chk("R6",    "load",   load_o,   m_load);
      chk("R7",    "word",   word_o,   m_word);
    end
    if (locked_o) lock_seen++;
    if (load_o)   load_seen++;
    @(negedge clk);
    n_last = tog;
    half_edge();
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL all-reqs watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int unsigned act;
    void'($urandom(32'h2C5A));
    // Directed: reset, then steady phase to reach lock (R1, R4)
    repeat (6) cycle();
    rst = 0;
    repeat (40) cycle();
    // Directed: long reset while the toggle keeps running (R8)
    rst = 1;
    repeat (20) cycle();
    rst = 0;
    repeat (30) cycle();
    // Directed: glitch on the toggle, lock must drop (R5)
    hc = 1;
    repeat (30) cycle();
    // Directed: one-edge slip (R5)
    hc = hc + 1;
    repeat (30) cycle();
    // Random disturbances
    for (int s = 0; s < 150; s++) begin
      act = $urandom % 6;
      case (act)
        0: hc = hc + 1;
        1: if (hc > 1) hc = hc - 1;
        2: hc = 1;
        3: begin
          rst = 1;
          repeat (1 + $urandom % 3) cycle();
          rst = 0;
        end
        default: ;
      endcase
      repeat (20 + $urandom % 40) cycle();
    end
    chk("R4", "lock ever seen", (lock_seen > 0), 1);
    chk("R6", "load ever seen", (load_seen > 0), 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule